// File: doc/BRIEF.md
# Integer ALU with Condition Bit

This block is the integer execution stage of a 32-bit processor. Each cycle it takes an operation code, a first operand, a second register operand, a raw 16-bit immediate and the current condition bit. It returns a registered 32-bit result, a write strobe for the destination register and the next value of the condition bit. Add, subtract, negate, logic, shift, compare and set-high operations are covered. Multiply, divide, floating point and memory access are not.

The second operand is either the register input or a form of the immediate. Each operation picks sign extension of the low 8 bits, sign extension of all 16 bits, zero extension of 16 bits, or the low 5 bits as a shift amount. The single condition bit has three uses. Checked arithmetic writes a signed-overflow flag into it. Extended arithmetic writes a carry or borrow into it. Compares write a less-than flag into it. Every other operation carries the incoming bit through unchanged.

Top module: `cbit_alu`

## Requirements
- R1: While `rst` is high at a rising edge, the registers clear: `res_o`=0, `wr_o`=0 and `c_o`=0 after that edge.
- R2: The outputs for the inputs present at a rising edge appear after that edge and stay until the next one. The latency is one cycle.
- R3: Op 0 gives a+b, op 1 gives a+sext(imm[15:0]) and op 2 gives a+sext(imm[7:0]). All three write the result and leave C unchanged.
- R4: Ops 10/12/14 give a AND/OR/XOR b. Ops 11/13/15 apply the same operators to a and zero-extended imm[15:0]. All six write the result and leave C unchanged.
- R5: Op 3 (a+b), op 4 (a+sext(imm16)) and op 7 (a-b) write the result. Each sets C to 1 exactly when the signed result overflows.
- R6: Op 5 writes a+b+C and sets C to the carry out of bit 31.
- R7: Op 8 writes a-b-C and sets C to 1 exactly when a < b+C as unsigned values.
- R8: Op 23 (a vs b) and op 24 (a vs sext(imm16)) set C to the signed less-than result. They assert no write and give `res_o`=0.
- R9: Op 25 compares a and b, and op 26 compares a and sext(imm16), both as unsigned values. Each sets C to the unsigned less-than result, asserts no write and gives `res_o`=0.
- R10: Op 9 writes 0-b and op 16 writes ~b. Both leave C unchanged. Op 6 writes a-b and also leaves C unchanged.
- R11: Shifts: ops 17/19/21 shift a left-logical, right-logical or right-arithmetic by b[4:0]. Ops 18/20/22 do the same by imm[4:0]. All write the result and leave C unchanged.
- R12: Op 27 writes {imm[15:0], 16'h0000} and leaves C unchanged.
- R13: Op codes 28 to 31 are not defined. They give `res_o`=0 and `wr_o`=0, and C passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_i | input | 5 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second register operand |
| imm_i | input | 16 | Raw immediate |
| c_i | input | 1 | Current condition bit |
| res_o | output | 32 | Registered result |
| wr_o | output | 1 | Registered result write strobe |
| c_o | output | 1 | Registered next condition bit |

## Verification
Each result, write strobe and condition bit is due exactly one rising edge after its inputs are applied. Between those edges the previous values hold. The bench drives every vector at a falling edge and waits for the next rising edge. It compares the outputs at the falling edge that follows, before it applies the next vector. A dedicated check looks at the outputs just after the inputs change, before the edge, and confirms that they still show the old values. The sweep covers every op code against corner operands, several immediates and both condition-bit values.

// File: rtl/cbit_alu_pkg.sv
package cbit_alu_pkg;

    localparam int XLEN     = 32;
    localparam int OP_W     = 5;
    localparam int IMM_LONG = 16;
    localparam int IMM_SHRT = 8;

    typedef enum logic [OP_W-1:0] {
        OP_ADD     = 5'd0,
        OP_ADD_S16 = 5'd1,
        OP_ADD_S8  = 5'd2,
        OP_ADDV    = 5'd3,
        OP_ADDV_S16= 5'd4,
        OP_ADDC    = 5'd5,
        OP_SUB     = 5'd6,
        OP_SUBV    = 5'd7,
        OP_SUBB    = 5'd8,
        OP_NEG     = 5'd9,
        OP_AND     = 5'd10,
        OP_AND_Z   = 5'd11,
        OP_OR      = 5'd12,
        OP_OR_Z    = 5'd13,
        OP_XOR     = 5'd14,
        OP_XOR_Z   = 5'd15,
        OP_NOT     = 5'd16,
        OP_SHL     = 5'd17,
        OP_SHL_I   = 5'd18,
        OP_SHR     = 5'd19,
        OP_SHR_I   = 5'd20,
        OP_SAR     = 5'd21,
        OP_SAR_I   = 5'd22,
        OP_CMPS    = 5'd23,
        OP_CMPS_I  = 5'd24,
        OP_CMPU    = 5'd25,
        OP_CMPU_I  = 5'd26,
        OP_SETHI   = 5'd27
    } op_e;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_ARITH = 2'd1,
        SRC_LOGIC = 2'd2
    } res_src_e;

    typedef struct packed {
        logic [XLEN-1:0] res;
        logic            wr;
        logic            c;
    } alu_out_t;

    function automatic logic is_compare(input op_e op);
        return (op == OP_CMPS) || (op == OP_CMPS_I) ||
               (op == OP_CMPU) || (op == OP_CMPU_I);
    endfunction

endpackage

// File: rtl/alu_opnd_sel.sv
module alu_opnd_sel
    import cbit_alu_pkg::*;
#(
    parameter int DATA_W  = XLEN,
    parameter int IMM_W   = IMM_LONG,
    parameter int IMM_S_W = IMM_SHRT
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] b_reg,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] b_eff
);
    localparam int SH_W = $clog2(DATA_W);

    logic [DATA_W-1:0] imm_sx_long;
    logic [DATA_W-1:0] imm_sx_short;
    logic [DATA_W-1:0] imm_zx_long;
    logic [DATA_W-1:0] imm_shamt;

    assign imm_sx_long  = {{(DATA_W-IMM_W){imm[IMM_W-1]}}, imm};
    assign imm_sx_short = {{(DATA_W-IMM_S_W){imm[IMM_S_W-1]}}, imm[IMM_S_W-1:0]};
    assign imm_zx_long  = {{(DATA_W-IMM_W){1'b0}}, imm};
    assign imm_shamt    = {{(DATA_W-SH_W){1'b0}}, imm[SH_W-1:0]};

    always_comb begin
        case (op)
            OP_ADD_S16, OP_ADDV_S16,
            OP_CMPS_I,  OP_CMPU_I:             b_eff = imm_sx_long;
            OP_ADD_S8:                         b_eff = imm_sx_short;
            OP_AND_Z, OP_OR_Z, OP_XOR_Z,
            OP_SETHI:                          b_eff = imm_zx_long;
            OP_SHL_I, OP_SHR_I, OP_SAR_I:      b_eff = imm_shamt;
            default:                           b_eff = b_reg;
        endcase
    end

endmodule

// File: rtl/alu_addsub.sv
module alu_addsub
    import cbit_alu_pkg::*;
#(
    parameter int DATA_W = XLEN
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              c_in,
    output logic [DATA_W-1:0] sum,
    output logic              c_next
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] x_opnd;
    logic [DATA_W-1:0] y_opnd;
    logic              cin;
    logic [DATA_W:0]   wide;
    logic              carry;
    logic              ovf;
    logic              lt_s;
    logic              lt_u;

    // One adder: subtraction folds into inverted y plus carry-in
    always_comb begin
        x_opnd = a;
        y_opnd = b;
        cin    = 1'b0;
        case (op)
            OP_ADDC: cin = c_in;
            OP_SUB, OP_SUBV, OP_CMPS, OP_CMPS_I, OP_CMPU, OP_CMPU_I: begin
                y_opnd = ~b;
                cin    = 1'b1;
            end
            OP_SUBB: begin
                y_opnd = ~b;
                cin    = ~c_in;
            end
            OP_NEG: begin
                x_opnd = '0;
                y_opnd = ~b;
                cin    = 1'b1;
            end
            default: ;
        endcase
    end

    assign wide  = {1'b0, x_opnd} + {1'b0, y_opnd} + {{DATA_W{1'b0}}, cin};
    assign sum   = wide[MSB:0];
    assign carry = wide[DATA_W];
    assign ovf   = (x_opnd[MSB] == y_opnd[MSB]) && (wide[MSB] != x_opnd[MSB]);
    assign lt_s  = wide[MSB] ^ ovf;
    assign lt_u  = ~carry;

    always_comb begin
        case (op)
            OP_ADDV, OP_ADDV_S16, OP_SUBV: c_next = ovf;
            OP_ADDC:                       c_next = carry;
            OP_SUBB:                       c_next = ~carry;
            OP_CMPS, OP_CMPS_I:            c_next = lt_s;
            OP_CMPU, OP_CMPU_I:            c_next = lt_u;
            default:                       c_next = c_in;
        endcase
    end

endmodule

// File: rtl/alu_logic_shift.sv
module alu_logic_shift
    import cbit_alu_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int IMM_W  = IMM_LONG
) (
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] lres
);
    localparam int SH_W = $clog2(DATA_W);

    logic [SH_W-1:0] shamt;
    assign shamt = b[SH_W-1:0];

    always_comb begin
        case (op)
            OP_AND, OP_AND_Z:   lres = a & b;
            OP_OR,  OP_OR_Z:    lres = a | b;
            OP_XOR, OP_XOR_Z:   lres = a ^ b;
            OP_NOT:             lres = ~b;
            OP_SHL, OP_SHL_I:   lres = a << shamt;
            OP_SHR, OP_SHR_I:   lres = a >> shamt;
            OP_SAR, OP_SAR_I:   lres = DATA_W'($signed(a) >>> shamt);
            OP_SETHI:           lres = {b[IMM_W-1:0], {(DATA_W-IMM_W){1'b0}}};
            default:            lres = '0;
        endcase
    end

endmodule

// File: rtl/cbit_alu.sv
module cbit_alu
    import cbit_alu_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int IMM_W  = IMM_LONG
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OP_W-1:0]   op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [IMM_W-1:0]  imm_i,
    input  logic              c_i,
    output logic [DATA_W-1:0] res_o,
    output logic              wr_o,
    output logic              c_o
);
    localparam int MSB = DATA_W - 1;

    op_e               op;
    logic [DATA_W-1:0] b_eff;
    logic [DATA_W-1:0] arith_res;
    logic [DATA_W-1:0] logic_res;
    logic              c_arith;
    res_src_e          src;
    logic [DATA_W-1:0] res_d;
    logic              wr_d;
    logic              c_d;

    assign op = op_e'(op_i);

    alu_opnd_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W), .IMM_S_W(IMM_SHRT)) u_sel (
        .op    (op),
        .b_reg (b_i),
        .imm   (imm_i),
        .b_eff (b_eff)
    );

    alu_addsub #(.DATA_W(DATA_W)) u_addsub (
        .op     (op),
        .a      (a_i),
        .b      (b_eff),
        .c_in   (c_i),
        .sum    (arith_res),
        .c_next (c_arith)
    );

    alu_logic_shift #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_lsh (
        .op   (op),
        .a    (a_i),
        .b    (b_eff),
        .lres (logic_res)
    );

    always_comb begin
        case (op)
            OP_ADD, OP_ADD_S16, OP_ADD_S8, OP_ADDV, OP_ADDV_S16, OP_ADDC,
            OP_SUB, OP_SUBV, OP_SUBB, OP_NEG:                 src = SRC_ARITH;
            OP_AND, OP_AND_Z, OP_OR, OP_OR_Z, OP_XOR, OP_XOR_Z, OP_NOT,
            OP_SHL, OP_SHL_I, OP_SHR, OP_SHR_I, OP_SAR, OP_SAR_I,
            OP_SETHI:                                          src = SRC_LOGIC;
            default:                                           src = SRC_NONE;
        endcase
    end

    always_comb begin
        case (src)
            SRC_ARITH: res_d = arith_res;
            SRC_LOGIC: res_d = logic_res;
            default:   res_d = '0;
        endcase
        wr_d = (src != SRC_NONE);
        c_d  = c_arith;
    end

    alu_out_t out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= '0;
        end else begin
            out_q.res <= res_d;
            out_q.wr  <= wr_d;
            out_q.c   <= c_d;
        end
    end

    assign res_o = out_q.res;
    assign wr_o  = out_q.wr;
    assign c_o   = out_q.c;

    // R8 / R9: a compare never raises the write strobe
    a_r8_cmp_no_write: assert property (@(posedge clk) disable iff (rst)
        (op_i inside {5'd23, 5'd24, 5'd25, 5'd26}) |=> (!wr_o && res_o == '0));

    // R5: operands of opposite sign cannot overflow an add
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (op_i == 5'd3 && a_i[MSB] != b_i[MSB]) |=> !c_o);

    // R13: ops that do not define C carry the incoming bit
    a_r13_c_passthrough: assert property (@(posedge clk) disable iff (rst)
        !(op_i inside {5'd3, 5'd4, 5'd5, 5'd7, 5'd8, 5'd23, 5'd24, 5'd25, 5'd26})
        |=> (c_o == $past(c_i)));

    // R12: set-high clears the low half
    a_r12_sethi_low: assert property (@(posedge clk) disable iff (rst)
        (op_i == 5'd27) |=> (res_o[IMM_W-1:0] == '0 && wr_o));

    // R10: negating zero gives zero
    a_r10_neg_zero: assert property (@(posedge clk) disable iff (rst)
        (op_i == 5'd9 && b_i == '0) |=> (res_o == '0));

    // R13: undefined codes never write
    a_r13_undef_no_write: assert property (@(posedge clk) disable iff (rst)
        (op_i >= 5'd28) |=> !wr_o);

endmodule

// File: tb/tb_cbit_alu.sv
module tb_cbit_alu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst;
    logic [4:0]  op_i;
    logic [31:0] a_i;
    logic [31:0] b_i;
    logic [15:0] imm_i;
    logic        c_i;
    logic [31:0] res_o;
    logic        wr_o;
    logic        c_o;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbit_alu dut (
        .clk   (clk),
        .rst   (rst),
        .op_i  (op_i),
        .a_i   (a_i),
        .b_i   (b_i),
        .imm_i (imm_i),
        .c_i   (c_i),
        .res_o (res_o),
        .wr_o  (wr_o),
        .c_o   (c_o)
    );

    function automatic logic [31:0] val(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h7FFF_FFFF;
            3: return 32'h8000_0000;
            4: return 32'hFFFF_FFFF;
            5: return 32'h0000_001F;
            6: return 32'h1234_5678;
            default: return 32'hFFFF_8001;
        endcase
    endfunction

    function automatic logic [15:0] ival(input int i);
        case (i)
            0: return 16'h0000;
            1: return 16'h7FFF;
            2: return 16'h8000;
            3: return 16'hFFA5;
            default: return 16'h0041;
        endcase
    endfunction

    function automatic string tag(input int op);
        if (op <= 2) return "R3";
        if (op == 3 || op == 4 || op == 7) return "R5";
        if (op == 5) return "R6";
        if (op == 8) return "R7";
        if (op == 6 || op == 9 || op == 16) return "R10";
        if (op >= 10 && op <= 15) return "R4";
        if (op >= 17 && op <= 22) return "R11";
        if (op == 23 || op == 24) return "R8";
        if (op == 25 || op == 26) return "R9";
        if (op == 27) return "R12";
        return "R13";
    endfunction

    // Returns {wr, c, res} from the requirement text
    function automatic logic [33:0] model(input int op, input logic [31:0] a,
                                          input logic [31:0] b, input logic [15:0] imm,
                                          input logic c);
        logic [31:0] s16, s8, z16, r;
        logic        wr, cn;
        longint      sa, sb, sr, ua, ub;
        logic [32:0] w;
        s16 = {{16{imm[15]}}, imm};
        s8  = {{24{imm[7]}}, imm[7:0]};
        z16 = {16'h0000, imm};
        r = 32'h0; wr = 1'b1; cn = c;
        sa = longint'($signed(a));
        case (op)
            0:  r = a + b;
            1:  r = a + s16;
            2:  r = a + s8;
            3, 4: begin
                sb = (op == 3) ? longint'($signed(b)) : longint'($signed(s16));
                sr = sa + sb;
                r  = a + ((op == 3) ? b : s16);
                cn = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            5:  begin w = {1'b0, a} + {1'b0, b} + {32'h0, c}; r = w[31:0]; cn = w[32]; end
            6:  r = a - b;
            7:  begin
                sr = sa - longint'($signed(b));
                r  = a - b;
                cn = (sr > 64'sd2147483647) || (sr < -64'sd2147483648);
            end
            8:  begin
                ua = longint'({32'h0, a}); ub = longint'({32'h0, b}) + longint'(c);
                r  = a - b - {31'h0, c};
                cn = ua < ub;
            end
            9:  r = 32'h0 - b;
            10: r = a & b;
            11: r = a & z16;
            12: r = a | b;
            13: r = a | z16;
            14: r = a ^ b;
            15: r = a ^ z16;
            16: r = ~b;
            17: r = a << b[4:0];
            18: r = a << imm[4:0];
            19: r = a >> b[4:0];
            20: r = a >> imm[4:0];
            21: r = $signed(a) >>> b[4:0];
            22: r = $signed(a) >>> imm[4:0];
            23: begin wr = 1'b0; cn = $signed(a) < $signed(b); end
            24: begin wr = 1'b0; cn = $signed(a) < $signed(s16); end
            25: begin wr = 1'b0; cn = a < b; end
            26: begin wr = 1'b0; cn = a < s16; end
            27: r = {imm, 16'h0000};
            default: wr = 1'b0;
        endcase
        return {wr, cn, r};
    endfunction

    task automatic check(input string req, input logic [33:0] act, input logic [33:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual wr=%0b c=%0b res=%h expected wr=%0b c=%0b res=%h",
                     req, act[33], act[32], act[31:0], exp[33], exp[32], exp[31:0]);
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; op_i = 5'd0; a_i = 32'h1; b_i = 32'h1; imm_i = 16'h0; c_i = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset clears every output
        check("R1", {wr_o, c_o, res_o}, 34'h0);
        rst = 1'b0;
        op_i = 5'd0; a_i = 32'd5; b_i = 32'd7; c_i = 1'b1;
        #1;
        // R2: before the edge the outputs still show the reset values
        check("R2", {wr_o, c_o, res_o}, 34'h0);
        @(posedge clk);
        @(negedge clk);
        // R2: one edge later the sum is present
        check("R2", {wr_o, c_o, res_o}, {1'b1, 1'b1, 32'd12});

        for (int op = 0; op < 32; op++) begin
            for (int ai = 0; ai < 8; ai++) begin
                for (int bi = 0; bi < 8; bi++) begin
                    for (int ii = 0; ii < 5; ii++) begin
                        for (int cv = 0; cv < 2; cv++) begin
                            op_i  = 5'(op);
                            a_i   = val(ai);
                            b_i   = val(bi);
                            imm_i = ival(ii);
                            c_i   = cv[0];
                            @(posedge clk);
                            @(negedge clk);
                            check(tag(op), {wr_o, c_o, res_o},
                                  model(op, val(ai), val(bi), ival(ii), cv[0]));
                        end
                    end
                end
            end
        end

        // R1: reset again after activity
        rst = 1'b1;
        @(posedge clk);
        @(negedge clk);
        check("R1", {wr_o, c_o, res_o}, 34'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule